// File: doc/BRIEF.md
# Quadrature Position Decoder with Timer Mode

This block turns the two phase signals and the index mark of an incremental rotary or linear encoder into a position count. All three encoder signals are brought into the clock domain first. A small decoder then turns each legal step of the two-bit Gray sequence into a count pulse with a direction. A counter applies that pulse, wrapping at a programmable maximum or clearing on the index mark. The same counter can also run as a free-standing prescaled timer whose direction software chooses.

Software reaches the block through a word-wide register port with three addresses. Address 0 is control and status. Address 1 is the position counter, which can be read or loaded. Address 2 is the maximum-count register. The control word packs its fields as follows: bits [2:0] select the mode, bit 3 swaps the phases, bit 4 enables the direction pin, bit 5 stops the block during idle, and bits [7:6] select the prescaler. Bit 8 holds the direction, bit 9 holds the sticky count-error flag, and bit 10 returns the synchronised index level. The upper bits read as zero.

Top module: `qdec_pos_unit`

## Requirements
- R1: After reset, the control word reads 0, the position reads 0, the maximum reads all ones, and both direction outputs are low.
- R2: In modes 110 and 111 (x4), each legal edge of either phase moves the count by one. The order A,B = 00→10→11→01→00 counts up, and the reverse order counts down. The count changes three clocks after the input edge.
- R3: In modes 100 and 101 (x2), only legal steps that toggle phase A move the count. Steps that toggle only phase B leave it unchanged.
- R4: A simultaneous change of both phases is an illegal jump and leaves the count and the direction unchanged.
- R5: With control bit 3 set, the phases are exchanged before decoding, so the same motion counts the opposite way.
- R6: When counting up from a value equal to the maximum, the count goes to 0. When counting down from 0, the count loads the maximum.
- R7: In modes 100 and 110, a rising index edge clears the count. If the count is then neither 0 nor the maximum, the index edge also sets the error flag (bit 9). In the other modes the index edge changes neither the count nor the flag.
- R8: The error flag stays set until a control write with bit 9 = 0.
- R9: In mode 001, the count steps once every 8^p clocks, where p is control bits [7:6]. It counts up when bit 8 is 1 and down when bit 8 is 0. In the decoding modes the prescaler has no effect.
- R10: Bit 8 reads 1 after an up step and 0 after a down step. A control write sets bit 8 only when the written mode field is 001. Otherwise the write leaves bit 8 unchanged.
- R11: With control bit 5 set and idle_i high, neither encoder motion nor the timer changes the count. With bit 5 clear, idle_i has no effect.
- R12: dir_oe_o follows control bit 4. While bit 4 is set, dir_o carries the direction bit; otherwise dir_o is low.
- R13: Modes 000, 010 and 011 hold the count.
- R14: Bit 10 of the control word shows the index input level two clocks after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a_i | input | 1 | Encoder phase A, asynchronous |
| phase_b_i | input | 1 | Encoder phase B, asynchronous |
| index_i | input | 1 | Encoder index mark, asynchronous |
| idle_i | input | 1 | System idle request |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select: 0 control, 1 position, 2 maximum |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| dir_o | output | 1 | Direction pin level |
| dir_oe_o | output | 1 | Direction pin output enable |

## Verification
A wrong Gray-code interpretation or a missed synchroniser stage shows up on the position read three clocks after a phase edge, either as a wrong count or as a count in the wrong cycle. A bad direction register shows up at once on dir_o and on bit 8. Wrap, index-clear and error-flag faults are only visible when the count sits at 0, at the maximum, or between them at an index edge. The stimulus therefore drives the count onto each of those boundaries. Prescaler faults appear as a drift of the timer count that grows with every period. For this reason the reference model is compared against the outputs on every clock rather than only at the end of a phase.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
   typedef enum logic [2:0] {
      MODE_OFF    = 3'd0,
      MODE_TIMER  = 3'd1,
      MODE_RSV2   = 3'd2,
      MODE_RSV3   = 3'd3,
      MODE_X2_IDX = 3'd4,
      MODE_X2_MAX = 3'd5,
      MODE_X4_IDX = 3'd6,
      MODE_X4_MAX = 3'd7
   } qmode_e;

   typedef struct packed {
      logic [1:0] presc;
      logic       idle_stop;
      logic       dir_oe;
      logic       swap;
      qmode_e     mode;
   } qctrl_t;

   localparam int CTRL_W  = 8;
   localparam int BIT_DIR = 8;
   localparam int BIT_ERR = 9;
   localparam int BIT_IDX = 10;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_POS  = 2'd1;
   localparam logic [1:0] ADDR_MAX  = 2'd2;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      for (genvar g = 0; g < W; g++) begin : g_bit
         logic [1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= 2'b00;
            else        stg <= {stg[0], d_i[g]};
         end
         assign q_o[g] = stg[1];
      end
   endgenerate
endmodule

// File: rtl/qdec_decoder.sv
module qdec_decoder (
   input  logic clk,
   input  logic rst_n,
   input  logic a_i,
   input  logic b_i,
   input  logic idx_i,
   input  logic x4_i,
   output logic step_o,
   output logic up_o,
   output logic idx_rise_o
);
   logic       prev_a, prev_b, prev_i;
   logic [1:0] ph_old, ph_new, delta;
   logic       fwd, rev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) {prev_a, prev_b, prev_i} <= 3'b000;
      else        {prev_a, prev_b, prev_i} <= {a_i, b_i, idx_i};
   end

   // Gray position: 00->0, 10->1, 11->2, 01->3
   assign ph_old = {prev_b, prev_a ^ prev_b};
   assign ph_new = {b_i, a_i ^ b_i};
   assign delta  = ph_new - ph_old;
   assign fwd    = (delta == 2'd1);
   assign rev    = (delta == 2'd3);

   assign step_o     = (fwd | rev) & (x4_i | (a_i ^ prev_a));
   assign up_o       = fwd;
   assign idx_rise_o = idx_i & ~prev_i;
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
   parameter int CNT_W    = 16,
   parameter int PRE_STEP = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             timer_i,
   input  logic             quad_i,
   input  logic             idx_mode_i,
   input  logic             dec_step_i,
   input  logic             dec_up_i,
   input  logic             idx_rise_i,
   input  logic             tdir_i,
   input  logic [1:0]       presc_i,
   input  logic [CNT_W-1:0] max_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] pos_o
);
   localparam int PRE_W = 3 * PRE_STEP;
   localparam logic [PRE_W:0] ONE = {{PRE_W{1'b0}}, 1'b1};

   logic [PRE_W:0]   pre_q, lim;
   logic             tick, step, up;
   logic [CNT_W-1:0] pos_q;

   assign lim  = (ONE << (PRE_STEP * int'(presc_i))) - ONE;
   assign tick = timer_i & run_i & (pre_q >= lim);
   assign step = quad_i ? dec_step_i : tick;
   assign up   = quad_i ? dec_up_i : tdir_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (!timer_i) pre_q <= '0;
      else if (run_i)   pre_q <= tick ? '0 : pre_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (load_i) begin
         pos_q <= load_val_i;
      end else if (run_i) begin
         if (idx_mode_i && idx_rise_i)
            pos_q <= '0;
         else if (step && up)
            pos_q <= (pos_q == max_i) ? '0 : pos_q + 1'b1;
         else if (step)
            pos_q <= (pos_q == '0) ? max_i : pos_q - 1'b1;
      end
   end

   assign pos_o = pos_q;
endmodule

// File: rtl/qdec_pos_unit.sv
module qdec_pos_unit
   import qdec_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int DATA_W   = 16,
   parameter int PRE_STEP = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phase_a_i,
   input  logic              phase_b_i,
   input  logic              index_i,
   input  logic              idle_i,
   input  logic              bus_we_i,
   input  logic [1:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              dir_o,
   output logic              dir_oe_o
);
   localparam int STAT_W = BIT_IDX + 1;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("qdec_pos_unit: CNT_W must be 2..DATA_W");
      end
      if (DATA_W < STAT_W) begin : g_bad_data
         $error("qdec_pos_unit: DATA_W too narrow for control word");
      end
      if (PRE_STEP < 1 || PRE_STEP > 4) begin : g_bad_pre
         $error("qdec_pos_unit: PRE_STEP must be 1..4");
      end
   endgenerate

   qctrl_t           ctrl_q;
   logic             dir_q, err_q;
   logic [CNT_W-1:0] max_q, pos;
   logic [2:0]       sync_q;
   logic             a_s, b_s, idx_s, a_e, b_e;
   logic             dec_step, dec_up, idx_rise;
   logic             quad, x4, idx_mode, timer, halt, run;
   logic             ctrl_wr, pos_wr, max_wr, ctrl_wr_timer, err_set;

   qdec_sync #(.W(3)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({index_i, phase_b_i, phase_a_i}),
      .q_o(sync_q)
   );
   assign {idx_s, b_s, a_s} = sync_q;
   assign a_e = ctrl_q.swap ? b_s : a_s;
   assign b_e = ctrl_q.swap ? a_s : b_s;

   assign quad     = ctrl_q.mode[2];
   assign x4       = ctrl_q.mode[1];
   assign idx_mode = quad & ~ctrl_q.mode[0];
   assign timer    = (ctrl_q.mode == MODE_TIMER);
   assign halt     = ctrl_q.idle_stop & idle_i;
   assign run      = ~halt;

   qdec_decoder u_dec (
      .clk(clk), .rst_n(rst_n),
      .a_i(a_e), .b_i(b_e), .idx_i(idx_s), .x4_i(x4),
      .step_o(dec_step), .up_o(dec_up), .idx_rise_o(idx_rise)
   );

   assign ctrl_wr       = bus_we_i && (bus_addr_i == ADDR_CTRL);
   assign pos_wr        = bus_we_i && (bus_addr_i == ADDR_POS);
   assign max_wr        = bus_we_i && (bus_addr_i == ADDR_MAX);
   assign ctrl_wr_timer = ctrl_wr && (bus_wdata_i[2:0] == MODE_TIMER);

   qdec_counter #(.CNT_W(CNT_W), .PRE_STEP(PRE_STEP)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .run_i(run), .timer_i(timer), .quad_i(quad), .idx_mode_i(idx_mode),
      .dec_step_i(dec_step), .dec_up_i(dec_up), .idx_rise_i(idx_rise),
      .tdir_i(dir_q), .presc_i(ctrl_q.presc), .max_i(max_q),
      .load_i(pos_wr), .load_val_i(bus_wdata_i[CNT_W-1:0]),
      .pos_o(pos)
   );

   assign err_set = run & idx_mode & idx_rise & (pos != '0) & (pos != max_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         max_q  <= '1;
         dir_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= qctrl_t'(bus_wdata_i[CTRL_W-1:0]);
         if (max_wr)  max_q  <= bus_wdata_i[CNT_W-1:0];
         if (ctrl_wr_timer)              dir_q <= bus_wdata_i[BIT_DIR];
         else if (quad && run && dec_step) dir_q <= dec_up;
         if (err_set)                           err_q <= 1'b1;
         else if (ctrl_wr && !bus_wdata_i[BIT_ERR]) err_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         ADDR_CTRL: begin
            bus_rdata_o[CTRL_W-1:0] = ctrl_q;
            bus_rdata_o[BIT_DIR]    = dir_q;
            bus_rdata_o[BIT_ERR]    = err_q;
            bus_rdata_o[BIT_IDX]    = idx_s;
         end
         ADDR_POS: bus_rdata_o[CNT_W-1:0] = pos;
         ADDR_MAX: bus_rdata_o[CNT_W-1:0] = max_q;
         default:  bus_rdata_o = '0;
      endcase
   end

   assign dir_oe_o = ctrl_q.dir_oe;
   assign dir_o    = dir_q & ctrl_q.dir_oe;
endmodule

// File: rtl/qdec_pos_unit_chk.sv
module qdec_pos_unit_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       mode,
   input logic             halt,
   input logic             pos_wr,
   input logic             ctrl_wr,
   input logic             ctrl_wr_timer,
   input logic [CNT_W-1:0] pos,
   input logic [CNT_W-1:0] max_v,
   input logic             dec_step,
   input logic             dec_up,
   input logic             idx_rise,
   input logic             err,
   input logic             dir
);
   // R2: in decoding modes the count only moves on a decoder step or index edge
   assert_no_spurious_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2] && !dec_step && !idx_rise && !pos_wr) |=> $stable(pos));

   // R6: up step at the maximum in match mode lands on zero
   assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2] && mode[0] && !halt && !pos_wr && dec_step && dec_up && pos == max_v)
      |=> (pos == '0));

   // R7: error flag only rises out of an index-reset mode
   assert_err_index_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> ($past(mode) == 3'd4 || $past(mode) == 3'd6));

   // R8: error flag is sticky without a control write
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !ctrl_wr) |=> err);

   // R10: direction only changes on a step or a timer-mode control write
   assert_dir_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2] && !dec_step && !ctrl_wr_timer) |=> $stable(dir));

   // R11: halted block holds its count
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !pos_wr) |=> $stable(pos));

   // R13: disabled modes hold the count
   assert_off_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[2] && mode != 3'd1 && !pos_wr) |=> $stable(pos));
endmodule

bind qdec_pos_unit qdec_pos_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .halt(halt),
   .pos_wr(pos_wr), .ctrl_wr(ctrl_wr), .ctrl_wr_timer(ctrl_wr_timer),
   .pos(pos), .max_v(max_q), .dec_step(dec_step), .dec_up(dec_up),
   .idx_rise(idx_rise), .err(err_q), .dir(dir_q)
);

// File: tb/qdec_pos_unit_bench.sv
`timescale 1ns/1ps
module qdec_pos_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phase_a = 1'b0, phase_b = 1'b0, index = 1'b0, idle = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        dir_o, dir_oe_o;

   int    errs = 0, checks = 0;
   bit    done = 0;
   string cur_req = "R1";
   logic  ea = 0, eb = 0;

   always #4 clk = ~clk;

   qdec_pos_unit u_qdec_pos_unit (
      .clk(clk), .rst_n(rst_n), .phase_a_i(phase_a), .phase_b_i(phase_b),
      .index_i(index), .idle_i(idle), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .dir_o(dir_o), .dir_oe_o(dir_oe_o)
   );

   // reference model state
   logic [2:0]  ms1, ms2;
   logic        mpa, mpb, mpi, mdir, merr;
   logic [15:0] mpos, mmax;
   logic [7:0]  mctl;
   int          mpc;

   function automatic logic [1:0] succ(input logic [1:0] s);
      case (s)
         2'b00:   return 2'b10;
         2'b10:   return 2'b11;
         2'b11:   return 2'b01;
         default: return 2'b00;
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin : model
      logic xa, xb, xi, fwd, rev, quad, x4, idxm, tmr, hlt, tick, step, up, rise;
      logic [15:0] exp_rd;
      int lim;
      if (!rst_n) begin
         ms1 = 0; ms2 = 0; mpa = 0; mpb = 0; mpi = 0; mdir = 0; merr = 0;
         mpos = 0; mmax = 16'hFFFF; mctl = 0; mpc = 0;
      end else begin
         xa = mctl[3] ? ms2[1] : ms2[0];
         xb = mctl[3] ? ms2[0] : ms2[1];
         xi = ms2[2];
         fwd  = ({xa, xb} == succ({mpa, mpb}));
         rev  = ({mpa, mpb} == succ({xa, xb}));
         quad = mctl[2];
         x4   = mctl[1];
         idxm = quad && !mctl[0];
         tmr  = (mctl[2:0] == 3'd1);
         hlt  = mctl[5] && idle;
         lim  = (1 << (3 * int'(mctl[7:6]))) - 1;
         tick = tmr && !hlt && (mpc >= lim);
         step = quad ? ((fwd || rev) && (x4 || xa != mpa)) : tick;
         up   = quad ? fwd : mdir;
         rise = xi && !mpi;
         if (!hlt && idxm && rise && mpos != 0 && mpos != mmax) merr = 1;
         else if (bus_we && bus_addr == 0 && !bus_wdata[9]) merr = 0;
         if (bus_we && bus_addr == 0 && bus_wdata[2:0] == 3'd1) mdir = bus_wdata[8];
         else if (quad && !hlt && step) mdir = fwd;
         if (bus_we && bus_addr == 1) mpos = bus_wdata;
         else if (!hlt) begin
            if (idxm && rise) mpos = 0;
            else if (step && up) mpos = (mpos == mmax) ? 16'd0 : mpos + 16'd1;
            else if (step) mpos = (mpos == 0) ? mmax : mpos - 16'd1;
         end
         if (!tmr) mpc = 0;
         else if (!hlt) mpc = tick ? 0 : mpc + 1;
         if (bus_we && bus_addr == 0) mctl = bus_wdata[7:0];
         if (bus_we && bus_addr == 2) mmax = bus_wdata;
         mpa = xa; mpb = xb; mpi = xi;
         ms2 = ms1;
         ms1 = {index, phase_b, phase_a};
      end
      #2;
      if (rst_n && !done) begin
         case (bus_addr)
            2'd0:    exp_rd = {5'b0, ms2[2], merr, mdir, mctl};
            2'd1:    exp_rd = mpos;
            2'd2:    exp_rd = mmax;
            default: exp_rd = 16'h0;
         endcase
         check({cur_req, " per-cycle rdata"}, bus_rdata, exp_rd);
         check({cur_req, " per-cycle dir_o"}, {15'b0, dir_o}, {15'b0, mdir & mctl[4]});
         check({cur_req, " per-cycle dir_oe"}, {15'b0, dir_oe_o}, {15'b0, mctl[4]});
      end
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      @(negedge clk); bus_addr = a; #1 v = bus_rdata;
   endtask

   task automatic mv(input bit f, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (f) begin if (ea == eb) ea = ~ea; else eb = ~eb; end
         else   begin if (ea == eb) eb = ~eb; else ea = ~ea; end
         phase_a = ea; phase_b = eb;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic jump();
      @(negedge clk); ea = ~ea; eb = ~eb; phase_a = ea; phase_b = eb;
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] v, saved;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      cur_req = "R1";
      rd(2'd0, v); check("R1 ctrl reset", v, 16'h0000);
      rd(2'd1, v); check("R1 pos reset", v, 16'h0000);
      rd(2'd2, v); check("R1 max reset", v, 16'hFFFF);
      check("R1 dir pins reset", {14'b0, dir_o, dir_oe_o}, 16'h0);

      cur_req = "R2";
      wr(2'd0, 16'h0007);
      mv(1, 8);
      rd(2'd1, v); check("R2 x4 forward 8", v, 16'd8);
      rd(2'd0, v); check("R10 dir up", {15'b0, v[8]}, 16'd1);
      mv(0, 3);
      rd(2'd1, v); check("R2 x4 reverse 3", v, 16'd5);

      cur_req = "R10";
      wr(2'd0, 16'h0107);
      rd(2'd0, v); check("R10 dir write ignored in quad", {15'b0, v[8]}, 16'd0);

      cur_req = "R3";
      wr(2'd0, 16'h0005);
      mv(1, 8);
      rd(2'd1, v); check("R3 x2 counts A edges only", v, 16'd9);

      cur_req = "R4";
      jump();
      rd(2'd1, v); check("R4 x2 illegal jump", v, 16'd9);
      wr(2'd0, 16'h0007);
      jump();
      rd(2'd1, v); check("R4 x4 illegal jump", v, 16'd9);

      cur_req = "R5";
      wr(2'd0, 16'h000F);
      mv(1, 4);
      rd(2'd1, v); check("R5 swap reverses", v, 16'd5);

      cur_req = "R6";
      wr(2'd2, 16'd9);
      wr(2'd0, 16'h0007);
      wr(2'd1, 16'd8);
      mv(1, 3);
      rd(2'd1, v); check("R6 wrap up past max", v, 16'd1);
      mv(0, 2);
      rd(2'd1, v); check("R6 wrap down to max", v, 16'd9);

      cur_req = "R7";
      wr(2'd0, 16'h0006);
      wr(2'd1, 16'd5);
      @(negedge clk); index = 1'b1;
      repeat (2) @(negedge clk);
      cur_req = "R14";
      rd(2'd0, v); check("R14 index level high", {15'b0, v[10]}, 16'd1);
      @(negedge clk); index = 1'b0;
      repeat (4) @(negedge clk);
      cur_req = "R7";
      rd(2'd1, v); check("R7 index clears count", v, 16'd0);
      rd(2'd0, v); check("R7 error set mid-range", {15'b0, v[9]}, 16'd1);
      check("R14 index level low", {15'b0, v[10]}, 16'd0);

      cur_req = "R8";
      repeat (5) @(negedge clk);
      rd(2'd0, v); check("R8 error sticky", {15'b0, v[9]}, 16'd1);
      wr(2'd0, 16'h0006);
      rd(2'd0, v); check("R8 error cleared", {15'b0, v[9]}, 16'd0);
      cur_req = "R7";
      @(negedge clk); index = 1'b1; repeat (4) @(negedge clk);
      index = 1'b0; repeat (4) @(negedge clk);
      rd(2'd0, v); check("R7 no error at zero", {15'b0, v[9]}, 16'd0);
      wr(2'd0, 16'h0007);
      wr(2'd1, 16'd5);
      @(negedge clk); index = 1'b1; repeat (4) @(negedge clk);
      index = 1'b0; repeat (4) @(negedge clk);
      rd(2'd1, v); check("R7 match mode ignores index", v, 16'd5);
      rd(2'd0, v); check("R7 match mode no error", {15'b0, v[9]}, 16'd0);

      cur_req = "R9";
      wr(2'd2, 16'hFFFF);
      wr(2'd1, 16'd0);
      wr(2'd0, 16'h0101);
      repeat (20) @(negedge clk);
      rd(2'd1, v); check("R9 timer div1 up", v, mpos);
      wr(2'd0, 16'h0141);
      repeat (100) @(negedge clk);
      rd(2'd1, v); check("R9 timer div8 up", v, mpos);
      wr(2'd0, 16'h0001);
      repeat (40) @(negedge clk);
      rd(2'd1, v); check("R9 timer down", v, mpos);
      wr(2'd0, 16'h01C1);
      repeat (1100) @(negedge clk);
      rd(2'd1, v); check("R9 timer div512", v, mpos);
      wr(2'd0, 16'h00C7);
      rd(2'd1, saved);
      mv(1, 2);
      rd(2'd1, v); check("R9 prescaler no effect in quad", v, saved + 16'd2);

      cur_req = "R11";
      wr(2'd0, 16'h0121);
      @(negedge clk); idle = 1'b1;
      rd(2'd1, saved);
      repeat (30) @(negedge clk);
      rd(2'd1, v); check("R11 timer halted in idle", v, saved);
      idle = 1'b0;
      repeat (10) @(negedge clk);
      wr(2'd0, 16'h0027);
      @(negedge clk); idle = 1'b1;
      rd(2'd1, saved);
      mv(1, 2);
      rd(2'd1, v); check("R11 quad halted in idle", v, saved);
      idle = 1'b0;
      wr(2'd0, 16'h0007);
      @(negedge clk); idle = 1'b1;
      mv(1, 1);
      rd(2'd1, v); check("R11 idle ignored without stop bit", v, saved + 16'd1);
      idle = 1'b0;

      cur_req = "R12";
      wr(2'd0, 16'h0017);
      mv(1, 1);
      #1 check("R12 dir pin up", {14'b0, dir_o, dir_oe_o}, 16'h3);
      mv(0, 1);
      #1 check("R12 dir pin down", {14'b0, dir_o, dir_oe_o}, 16'h1);
      wr(2'd0, 16'h0007);
      mv(1, 1);
      #1 check("R12 dir pin released", {14'b0, dir_o, dir_oe_o}, 16'h0);

      cur_req = "R13";
      rd(2'd1, saved);
      wr(2'd0, 16'h0000);
      mv(1, 3);
      wr(2'd0, 16'h0102);
      repeat (10) @(negedge clk);
      wr(2'd0, 16'h0003);
      mv(0, 2);
      rd(2'd1, v); check("R13 disabled modes hold", v, saved);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule